// File: doc/BRIEF.md
# Pipelined Eighth-Root Constant Multiplier

This block multiplies a stream of complex samples by one of two fixed eighth-roots of unity. One is W8^1 = (√2/2)(1 − j) and the other is W8^3 = (√2/2)(−1 − j). It serves as the constant-rotation stage of a radix-2/8 butterfly. No hardware multiplier is used.

For each sample `a + jb`, the block forms the sum `a + b` and the difference `b − a` once, with one guard bit. Both constants share these two values. Each value is scaled by √2/2 through a fixed signed-digit shift-and-add chain that carries exact fractional bits. The result is rounded to the nearest integer, and a per-sample select arranges the two scaled values into the output. The W8^3 arrangement negates the imaginary part. Each output is saturated to 16 bits.

A new sample may enter on every cycle. Each sample keeps its own select through the pipeline, and the result appears a fixed four cycles later.

Top module: `w8_const_mult`

## Requirements
- R1: While `rst_n` is low, every clock edge clears `out_valid`, `out_re` and `out_im` to zero.
- R2: `out_valid` is a copy of `in_valid` delayed by exactly 4 clock cycles. Gaps in the input stream are kept as gaps in the output stream.
- R3: With `in_sel` = 0 (W8^1), `out_re` is within 1 LSB of (√2/2)(a+b) and `out_im` is within 1 LSB of (√2/2)(b−a). Here a = `in_re` and b = `in_im`, both two's complement.
- R4: With `in_sel` = 1 (W8^3), `out_re` is within 1 LSB of (√2/2)(b−a) and `out_im` is within 1 LSB of −(√2/2)(a+b).
- R5: A result outside the 16-bit range is clipped to 32767 or −32768. For example, a = b = −32768 with W8^1 gives `out_re` = −32768, and with W8^3 gives `out_im` = 32767.
- R6: Samples accepted on consecutive cycles each produce their own correct result on consecutive output cycles.
- R7: The select is sampled together with its data. Changing `in_sel` from one cycle to the next changes only the result of the sample it came with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_sel | input | 1 | Constant choice: 0 = W8^1, 1 = W8^3 |
| in_re | input | 16 | Real part a, two's complement |
| in_im | input | 16 | Imaginary part b, two's complement |
| out_valid | output | 1 | Result present this cycle |
| out_re | output | 16 | Real part of the product |
| out_im | output | 16 | Imaginary part of the product |

## Verification
The bench concentrates on the extremes. Both parts at −32768, or both at 32767, drive the guard-bit sum to its limits; a design without the guard bit or without clipping would wrap around and return a result of the wrong sign. Inputs with equal parts, and inputs with a zero sum, check that the correct term vanishes for each constant; a swapped mux arm or a missing negation would leave the wrong part non-zero. Back-to-back samples with an alternating select, and sparse samples separated by gaps, expose a select or valid signal that is out of step with its data by one stage. Small magnitudes such as ±1 and ±2 expose a design that truncates instead of rounding or that has dropped low-order terms of the constant.

// File: rtl/w8cm_pkg.sv
// Shared types for the eighth-root constant multiplier.
// Assumes nothing beyond the select encoding used by all submodules.
package w8cm_pkg;
    // Which rotation constant a sample is multiplied by.
    typedef enum logic {
        ROT_W1 = 1'b0,   // (sqrt2/2)(1 - j)
        ROT_W3 = 1'b1    // (sqrt2/2)(-1 - j)
    } rot_sel_e;
endpackage

// File: rtl/w8cm_prep.sv
// Input stage: registers the guard-bit sum a+b and difference b-a of a sample.
// Assumes IW = DW + 1, so neither value can overflow.
module w8cm_prep #(
    parameter int DW = 16,
    parameter int IW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_in,
    input  logic signed [DW-1:0] b_in,
    output logic signed [IW-1:0] sum_q,
    output logic signed [IW-1:0] dif_q
);
    logic signed [IW-1:0] a_x;
    logic signed [IW-1:0] b_x;

    // Sign-extend both parts by the guard bit.
    always_comb begin
        a_x = {a_in[DW-1], a_in};
        b_x = {b_in[DW-1], b_in};
    end

    // Register the shared sum and difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            dif_q <= '0;
        end else begin
            sum_q <= a_x + b_x;
            dif_q <= b_x - a_x;
        end
    end
endmodule

// File: rtl/w8cm_scale.sv
// Multiplies a guard-bit value by sqrt(2)/2 using only shifts and adds.
// The constant is 1 - 2^-2 - 2^-4 + 2^-6 + 2^-8 + 2^-14 + 2^-16 (error below 1e-6).
// Two registered stages; the product keeps FW fractional bits. Assumes FW >= 16,
// so that every shifted term is exact.
module w8cm_scale #(
    parameter int IW = 17,
    parameter int FW = 16,
    parameter int EW = IW + FW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [IW-1:0] x_in,
    output logic signed [EW-1:0] prod_q
);
    logic signed [EW-1:0] x_e;
    logic signed [EW-1:0] part_hi_q;
    logic signed [EW-1:0] part_lo_q;

    // Place the integer value above FW fractional zero bits.
    always_comb x_e = {x_in, {FW{1'b0}}};

    // Stage 1: the coarse digits and the fine digits, summed separately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_hi_q <= '0;
            part_lo_q <= '0;
        end else begin
            part_hi_q <= x_e - (x_e >>> 2) - (x_e >>> 4);
            part_lo_q <= (x_e >>> 6) + (x_e >>> 8) + (x_e >>> 14) + (x_e >>> 16);
        end
    end

    // Stage 2: combine the two partial sums into the scaled product.
    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= part_hi_q + part_lo_q;
    end
endmodule

// File: rtl/w8cm_finish.sv
// Output stage: rounds both scaled values to the nearest integer, arranges them
// by the constant select (negating for W8^3), saturates to DW bits and registers.
// Assumes the scaled magnitudes fit in DW+2 bits after rounding.
module w8cm_finish
    import w8cm_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 16,
    parameter int EW = DW + 1 + FW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_in,
    input  rot_sel_e             sel_in,
    input  logic signed [EW-1:0] sum_p,
    input  logic signed [EW-1:0] dif_p,
    output logic                 vld_q,
    output logic signed [DW-1:0] re_q,
    output logic signed [DW-1:0] im_q
);
    localparam int RW = DW + 2;
    localparam logic signed [EW-1:0] HALF = {{(EW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};
    localparam logic signed [RW-1:0] POS_LIM = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [RW-1:0] NEG_LIM = {3'b111, {(DW-1){1'b0}}};

    logic signed [RW-1:0] r_sum;
    logic signed [RW-1:0] r_dif;
    logic signed [RW-1:0] pre_re;
    logic signed [RW-1:0] pre_im;

    // Clip an RW-bit value to the DW-bit two's-complement range.
    function automatic logic signed [DW-1:0] clip(input logic signed [RW-1:0] v);
        if (v > POS_LIM)      clip = DW'(POS_LIM);
        else if (v < NEG_LIM) clip = DW'(NEG_LIM);
        else                  clip = DW'(v);
    endfunction

    // Round half up, then choose the arrangement for the selected constant.
    always_comb begin
        r_sum = RW'((sum_p + HALF) >>> FW);
        r_dif = RW'((dif_p + HALF) >>> FW);
        if (sel_in == ROT_W3) begin
            pre_re = r_dif;
            pre_im = -r_sum;
        end else begin
            pre_re = r_sum;
            pre_im = r_dif;
        end
    end

    // Register the saturated result with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            re_q  <= '0;
            im_q  <= '0;
        end else begin
            vld_q <= vld_in;
            re_q  <= clip(pre_re);
            im_q  <= clip(pre_im);
        end
    end
endmodule

// File: rtl/w8_const_mult.sv
// Top: multiplies complex samples by W8^1 or W8^3 with a fixed latency of
// LAT cycles and full throughput. The valid flag and the select travel beside
// the data in their own shift register so that each stays with its own sample.
module w8_const_mult
    import w8cm_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sel,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im
);
    localparam int IW        = DW + 1;
    localparam int EW        = IW + FW;
    localparam int SCALE_LAT = 2;
    localparam int TAG_DEPTH = SCALE_LAT + 1;
    localparam int LAT       = TAG_DEPTH + 1;

    logic signed [IW-1:0] pair_in [2];
    logic signed [EW-1:0] pair_out[2];
    logic                 vld_pipe[TAG_DEPTH];
    rot_sel_e             sel_pipe[TAG_DEPTH];
    logic signed [DW-1:0] re_s;
    logic signed [DW-1:0] im_s;

    w8cm_prep #(.DW(DW), .IW(IW)) u_prep (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (in_re),
        .b_in  (in_im),
        .sum_q (pair_in[0]),
        .dif_q (pair_in[1])
    );

    // One scaling chain each for the shared sum and the shared difference.
    for (genvar g = 0; g < 2; g++) begin : g_scale
        w8cm_scale #(.IW(IW), .FW(FW), .EW(EW)) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .x_in   (pair_in[g]),
            .prod_q (pair_out[g])
        );
    end

    // Valid and select tags follow the data through the prep and scale stages.
    for (genvar k = 0; k < TAG_DEPTH; k++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_pipe[k] <= 1'b0;
                sel_pipe[k] <= ROT_W1;
            end else if (k == 0) begin
                vld_pipe[k] <= in_valid;
                sel_pipe[k] <= rot_sel_e'(in_sel);
            end else begin
                vld_pipe[k] <= vld_pipe[(k == 0) ? 0 : k-1];
                sel_pipe[k] <= sel_pipe[(k == 0) ? 0 : k-1];
            end
        end
    end

    w8cm_finish #(.DW(DW), .FW(FW), .EW(EW)) u_finish (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_in (vld_pipe[TAG_DEPTH-1]),
        .sel_in (sel_pipe[TAG_DEPTH-1]),
        .sum_p  (pair_out[0]),
        .dif_p  (pair_out[1]),
        .vld_q  (out_valid),
        .re_q   (re_s),
        .im_q   (im_s)
    );

    // Present the signed results on the plain output ports.
    always_comb begin
        out_re = re_s;
        out_im = im_s;
    end
endmodule

// File: rtl/w8cm_checker.sv
// Temporal checks for w8_const_mult, attached with bind. A saturating count of
// the cycles since reset keeps every 4-cycle look-back inside the post-reset window.
module w8cm_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sel,
    input logic [DW-1:0] in_re,
    input logic [DW-1:0] in_im,
    input logic          out_valid,
    input logic [DW-1:0] out_re,
    input logic [DW-1:0] out_im
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    logic [2:0] since_rst;

    // Count the clock edges since reset was released, stopping at 7.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_re == '0 && out_im == '0)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4))); // R2

    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(in_valid && in_re == '0 && in_im == '0, 4))
        |-> (out_re == '0 && out_im == '0)); // R3

    AST_W1_EQUAL_PARTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(in_valid && !in_sel && in_re == in_im, 4))
        |-> (out_im == '0)); // R3

    AST_W3_EQUAL_PARTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(in_valid && in_sel && in_re == in_im, 4))
        |-> (out_re == '0)); // R4

    AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(in_valid && !in_sel && in_re == MOST_NEG && in_im == MOST_NEG, 4))
        |-> (out_re == MOST_NEG)); // R5

    AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && $past(in_valid && in_sel && in_re == MOST_NEG && in_im == MOST_NEG, 4))
        |-> (out_im == MOST_POS)); // R5
endmodule

bind w8_const_mult w8cm_checker #(.DW(DW)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sel    (in_sel),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/tb_w8_const_mult.sv
// Bench: walks a table of stimulus vectors back to back, then runs directed
// gap, corner and mid-stream reset tests. Expected values come from an ideal
// real-valued product, rounded and clipped, with a tolerance of 1 LSB.
module tb_w8_const_mult;
    localparam int    DW    = 16;
    localparam int    LAT   = 4;
    localparam int    NVEC  = 20;
    localparam real   HALFR = 0.70710678118654752;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sel = 1'b0;
    logic [DW-1:0] in_re = '0;
    logic [DW-1:0] in_im = '0;
    logic          out_valid;
    logic [DW-1:0] out_re;
    logic [DW-1:0] out_im;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Stimulus table: {select, real part, imaginary part}.
    localparam logic [2*DW:0] VEC [NVEC] = '{
        {1'b0,  16'sd1000,   16'sd0},
        {1'b1,  16'sd1000,   16'sd0},
        {1'b0,  16'sd0,      16'sd1000},
        {1'b1,  16'sd0,      16'sd1000},
        {1'b0,  16'sd1,      16'sd1},
        {1'b1, -16'sd1,      16'sd2},
        {1'b0,  16'sd12345, -16'sd6789},
        {1'b1,  16'sd12345, -16'sd6789},
        {1'b0, -16'sd20000, -16'sd15000},
        {1'b1, -16'sd20000, -16'sd15000},
        {1'b0,  16'sd32767,  16'sd32767},
        {1'b1,  16'sd32767,  16'sd32767},
        {1'b0, -16'sd32768, -16'sd32768},
        {1'b1, -16'sd32768, -16'sd32768},
        {1'b0,  16'sd32767, -16'sd32768},
        {1'b1,  16'sd32767, -16'sd32768},
        {1'b0,  16'sd0,      16'sd0},
        {1'b1,  16'sd777,   -16'sd777},
        {1'b0, -16'sd3,      16'sd5},
        {1'b1,  16'sd23170,  16'sd23171}
    };

    w8_const_mult dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sel    (in_sel),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    always #10 clk = ~clk;

    // Round to nearest and clip to 16 bits.
    function automatic int ideal(input real v);
        int r;
        r = int'($floor(v + 0.5));
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check_val(input string tag, input string what, input int got, input int exp, input int tol);
        int diff;
        n_checks++;
        diff = got - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Input history as seen at each falling edge, four deep.
    logic          h_v  [LAT];
    logic          h_s  [LAT];
    int            h_a  [LAT];
    int            h_b  [LAT];
    bit            rst_prev = 1'b0;

    // Monitor: compare outputs with the sample presented four falling edges ago.
    always @(negedge clk) begin
        int s, d, er, ei;
        string tag;
        if (!rst_n) begin
            if (rst_prev) begin
                check_val("R1", "out_valid in reset", int'(out_valid), 0, 0);
                check_val("R1", "out_re in reset", int'($signed(out_re)), 0, 0);
                check_val("R1", "out_im in reset", int'($signed(out_im)), 0, 0);
            end
            rst_prev = 1'b1;
            for (int k = 0; k < LAT; k++) begin
                h_v[k] = 1'b0; h_s[k] = 1'b0; h_a[k] = 0; h_b[k] = 0;
            end
        end else begin
            rst_prev = 1'b0;
            check_val("R2", "out_valid timing", int'(out_valid), int'(h_v[LAT-1]), 0);
            if (h_v[LAT-1] && out_valid) begin
                s = h_a[LAT-1] + h_b[LAT-1];
                d = h_b[LAT-1] - h_a[LAT-1];
                if (h_s[LAT-1]) begin
                    er = ideal(HALFR * d);
                    ei = ideal(-HALFR * s);
                    tag = "R4/R5/R6/R7";
                end else begin
                    er = ideal(HALFR * s);
                    ei = ideal(HALFR * d);
                    tag = "R3/R5/R6/R7";
                end
                check_val(tag, "out_re", int'($signed(out_re)), er, 1);
                check_val(tag, "out_im", int'($signed(out_im)), ei, 1);
            end
            for (int k = LAT-1; k > 0; k--) begin
                h_v[k] = h_v[k-1]; h_s[k] = h_s[k-1]; h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1];
            end
            h_v[0] = in_valid;
            h_s[0] = in_sel;
            h_a[0] = int'($signed(in_re));
            h_b[0] = int'($signed(in_im));
        end
    end

    task automatic push(input logic sel, input logic [DW-1:0] a, input logic [DW-1:0] b);
        in_valid = 1'b1; in_sel = sel; in_re = a; in_im = b;
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; in_re = 16'h5A5A; in_im = 16'hA5A5; in_sel = ~in_sel;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset held for several edges; the monitor checks zeros.
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R6, R7: the whole table back to back, select changing per sample.
        for (int i = 0; i < NVEC; i++) begin
            push(VEC[i][2*DW], VEC[i][2*DW-1:DW], VEC[i][DW-1:0]);
        end
        idle(6);

        // R2: isolated samples separated by gaps of different lengths.
        push(1'b0, 16'sd100, 16'sd200);
        idle(2);
        push(1'b1, 16'sd100, 16'sd200);
        idle(1);
        push(1'b0, -16'sd2, -16'sd2);
        idle(6);

        // R5: clipping corners in both arrangements, back to back.
        push(1'b1, -16'sd32768, -16'sd32768);
        push(1'b0, -16'sd32768, -16'sd32768);
        push(1'b1,  16'sd32767,  16'sd32767);
        push(1'b0, -16'sd32768,  16'sd32767);
        push(1'b1, -16'sd32768,  16'sd32767);
        idle(6);

        // R1: reset in the middle of a stream flushes everything in flight.
        push(1'b0, 16'sd5000, 16'sd6000);
        push(1'b1, 16'sd5000, 16'sd6000);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) begin
            @(posedge clk); #2;
        end
        rst_n = 1'b1;
        idle(6);

        // R3, R4: a final pair after reset recovery.
        push(1'b0, 16'sd300, -16'sd100);
        push(1'b1, 16'sd300, -16'sd100);
        idle(6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule